// File: doc/BRIEF.md
# Legacy Interrupt Routing Matrix

This block sits inside a legacy PC I/O controller. It takes the raw interrupt requests of several logical peripherals and steers each one onto one of fifteen shared ISA interrupt lines. Every logical device owns a 4-bit level-select register. A value of zero leaves the device unrouted. A value n from 1 to 15 steers it to line IRQn. A request only reaches its line while the device's own enable conditions hold. Those conditions depend on the device kind: floppy controller, parallel port, serial port or keyboard.

Software reaches the select registers through a small configuration port. A request strobe carries a device number, a register index, a write flag and a data byte. A two-state access machine accepts the request and acknowledges it one cycle later, returning read data in that cycle. Its states are `CFG_IDLE` and `CFG_ACCESS`. It moves from `CFG_IDLE` to `CFG_ACCESS` when a request arrives, and from `CFG_ACCESS` back to `CFG_IDLE` unconditionally. A bus reset returns it to `CFG_IDLE` from either state.

Each interrupt line has a data bit and an output-enable bit. A line is enabled while at least one device selects it. It floats (enable low, data low) while no device selects it. Routing from request to pin is combinational.

Top module: `irq_route_matrix`

## Requirements
- R1: After power-on reset (`rst_n` low), every select register is 0, `irq_oe` and `irq_dat` are all zero, and a read of any select register returns 0x00.
- R2: A request accepted in `CFG_IDLE` raises `cfg_ack` for exactly the next cycle. During that cycle `cfg_rdata` shows `{4'b0, select}` for a read or write of index 0x70 on an existing device. A write stores `cfg_wdata[3:0]` at the end of the ack cycle and discards `cfg_wdata[7:4]`.
- R3: An access to any index other than 0x70, or to a device number of `NUM_DEV` or above, changes no select register and reads 0x00.
- R4: Bit p of `irq_oe` / `irq_dat` stands for line IRQ(p+1). A select value n in 1..15 enables bit n-1. Select 0 enables no bit.
- R5: Floppy device (kind 0): its request is gated by status bit 3, the DMA enable.
- R6: Parallel device (kind 1): its request needs status bit 4 (interrupt enable) set. When status bit 7 (extended mode) is set, it also needs status bit 2 (service flag) clear.
- R7: Serial device (kind 2): its request needs at least one of status bits 3..0 set, and status bit 5 (OUT2) set.
- R8: Keyboard device (kind 3): its request is gated by status bit 0.
- R9: When several devices select the same line, that line's data is the OR of their gated requests.
- R10: A selected line whose gated requests are all false is driven low with its enable high. A data bit is never 1 while its enable is 0.
- R11: A cycle with `bus_reset` high clears every select register, so all enables are low after that edge. This takes priority over a write in the same cycle.
- R12: A request held high for consecutive cycles is served every other cycle: `cfg_ack` is never high in two adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_reset | input | 1 | Synchronous bus reset, active high |
| cfg_req | input | 1 | Configuration access strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_dev | input | DEV_W | Logical device number |
| cfg_idx | input | 8 | Register index within the device |
| cfg_wdata | input | 8 | Write data |
| cfg_ack | output | 1 | Access acknowledge, one cycle |
| cfg_rdata | output | 8 | Read data, valid with `cfg_ack` |
| dev_req | input | NUM_DEV | Raw interrupt request per device |
| dev_stat | input | 8*NUM_DEV | Enable status byte per device, device d at bits [8d+7:8d] |
| irq_dat | output | 15 | Line values, bit p = IRQ(p+1) |
| irq_oe | output | 15 | Line output enables, bit p = IRQ(p+1) |

## Verification
A corrupted select register shows at the ports right away. The enable of the wrong line rises, or the right one stays low, in the same cycle that the register changes. The next read through the configuration port also returns the bad value. A stuck or skipped state in the access machine shows as a missing, doubled or adjacent `cfg_ack` within one to two cycles of a request. A wrong gate for one device kind appears on the data bit of its line as soon as that device's status byte is changed.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int SEL_W     = 4;
    localparam int NUM_LINES = 15;
    localparam int STAT_W    = 8;
    localparam logic [7:0] SEL_INDEX = 8'h70;

    typedef enum logic [1:0] {
        KIND_FLOPPY   = 2'd0,
        KIND_PARALLEL = 2'd1,
        KIND_SERIAL   = 2'd2,
        KIND_KEYBOARD = 2'd3
    } dev_kind_e;

    typedef enum logic {
        CFG_IDLE   = 1'b0,
        CFG_ACCESS = 1'b1
    } cfg_state_e;

    // status byte bit positions, one set per device kind
    localparam int FLP_DMA_EN   = 3;
    localparam int PAR_IRQ_EN   = 4;
    localparam int PAR_SERVICE  = 2;
    localparam int PAR_EXT_MODE = 7;
    localparam int SER_OUT2     = 5;
    localparam int KBD_EN       = 0;
endpackage

// File: rtl/irq_cfg_fsm.sv
module irq_cfg_fsm
    import irq_route_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int DEV_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_reset,
    input  logic                 cfg_req,
    input  logic                 cfg_we,
    input  logic [DEV_W-1:0]     cfg_dev,
    input  logic [7:0]           cfg_idx,
    input  logic [SEL_W-1:0]     cfg_wnib,
    output logic                 acc_ack,
    output logic                 acc_hit,
    output logic                 acc_wr,
    output logic [DEV_W-1:0]     acc_dev,
    output logic [SEL_W-1:0]     acc_data
);
    cfg_state_e             state_q, state_d;
    logic                   we_q;
    logic [DEV_W-1:0]       dev_q;
    logic [7:0]             idx_q;
    logic [SEL_W-1:0]       data_q;
    logic                   accept;

    assign accept = (state_q == CFG_IDLE) && cfg_req;

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CFG_IDLE;
            we_q    <= 1'b0;
            dev_q   <= '0;
            idx_q   <= '0;
            data_q  <= '0;
        end else begin
            if (bus_reset) begin
                state_q <= CFG_IDLE;
            end else begin
                state_q <= state_d;
            end
            if (accept && !bus_reset) begin
                we_q   <= cfg_we;
                dev_q  <= cfg_dev;
                idx_q  <= cfg_idx;
                data_q <= cfg_wnib;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_IDLE:   state_d = cfg_req ? CFG_ACCESS : CFG_IDLE;
            CFG_ACCESS: state_d = CFG_IDLE;
            default:    state_d = CFG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        acc_ack  = 1'b0;
        acc_hit  = 1'b0;
        acc_wr   = 1'b0;
        acc_dev  = dev_q;
        acc_data = data_q;
        unique case (state_q)
            CFG_IDLE: begin
                acc_ack = 1'b0;
            end
            CFG_ACCESS: begin
                acc_ack = 1'b1;
                acc_hit = (idx_q == SEL_INDEX) && (32'(dev_q) < NUM_DEV);
                acc_wr  = acc_hit && we_q;
            end
            default: begin
                acc_ack = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/irq_sel_bank.sv
module irq_sel_bank
    import irq_route_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int DEV_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_reset,
    input  logic                       wr_en,
    input  logic [DEV_W-1:0]           wr_dev,
    input  logic [SEL_W-1:0]           wr_data,
    output logic [NUM_DEV*SEL_W-1:0]   sel_flat
);
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_sel
        logic [SEL_W-1:0] sel_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_q <= '0;
            end else if (bus_reset) begin
                sel_q <= '0;
            end else if (wr_en && (wr_dev == DEV_W'(d))) begin
                sel_q <= wr_data;
            end
        end
        assign sel_flat[d*SEL_W +: SEL_W] = sel_q;
    end
endmodule

// File: rtl/irq_dev_gate.sv
module irq_dev_gate
    import irq_route_pkg::*;
#(
    parameter dev_kind_e KIND = KIND_FLOPPY
) (
    input  logic              req,
    input  logic [STAT_W-1:0] stat,
    output logic              gated
);
    logic unused_stat_bits;
    assign unused_stat_bits = ^stat;

    if (KIND == KIND_FLOPPY) begin : g_flp
        assign gated = req && stat[FLP_DMA_EN];
    end else if (KIND == KIND_PARALLEL) begin : g_par
        assign gated = req && stat[PAR_IRQ_EN]
                       && !(stat[PAR_EXT_MODE] && stat[PAR_SERVICE]);
    end else if (KIND == KIND_SERIAL) begin : g_ser
        assign gated = req && (|stat[3:0]) && stat[SER_OUT2];
    end else begin : g_kbd
        assign gated = req && stat[KBD_EN];
    end
endmodule

// File: rtl/irq_pin_mux.sv
module irq_pin_mux
    import irq_route_pkg::*;
#(
    parameter int NUM_DEV = 4
) (
    input  logic [NUM_DEV*SEL_W-1:0] sel_flat,
    input  logic [NUM_DEV-1:0]       gated,
    output logic [NUM_LINES-1:0]     line_dat,
    output logic [NUM_LINES-1:0]     line_oe
);
    for (genvar p = 0; p < NUM_LINES; p++) begin : g_line
        always_comb begin
            line_dat[p] = 1'b0;
            line_oe[p]  = 1'b0;
            for (int d = 0; d < NUM_DEV; d++) begin
                if (sel_flat[d*SEL_W +: SEL_W] == SEL_W'(p + 1)) begin
                    line_oe[p]  = 1'b1;
                    line_dat[p] = line_dat[p] | gated[d];
                end
            end
        end
    end
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
    import irq_route_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int DEV_W   = 3,
    parameter logic [2*NUM_DEV-1:0] DEV_KINDS = 8'b11_10_01_00
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_reset,
    input  logic                      cfg_req,
    input  logic                      cfg_we,
    input  logic [DEV_W-1:0]          cfg_dev,
    input  logic [7:0]                cfg_idx,
    input  logic [7:0]                cfg_wdata,
    output logic                      cfg_ack,
    output logic [7:0]                cfg_rdata,
    input  logic [NUM_DEV-1:0]        dev_req,
    input  logic [NUM_DEV*STAT_W-1:0] dev_stat,
    output logic [NUM_LINES-1:0]      irq_dat,
    output logic [NUM_LINES-1:0]      irq_oe
);
    logic                     acc_hit, acc_wr;
    logic [DEV_W-1:0]         acc_dev;
    logic [SEL_W-1:0]         acc_data;
    logic [NUM_DEV*SEL_W-1:0] sel_flat;
    logic [NUM_DEV-1:0]       gated;
    logic                     unused_wdata_hi;

    assign unused_wdata_hi = ^cfg_wdata[7:SEL_W];

    irq_cfg_fsm #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .cfg_req   (cfg_req),
        .cfg_we    (cfg_we),
        .cfg_dev   (cfg_dev),
        .cfg_idx   (cfg_idx),
        .cfg_wnib  (cfg_wdata[SEL_W-1:0]),
        .acc_ack   (cfg_ack),
        .acc_hit   (acc_hit),
        .acc_wr    (acc_wr),
        .acc_dev   (acc_dev),
        .acc_data  (acc_data)
    );

    irq_sel_bank #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .wr_en     (acc_wr),
        .wr_dev    (acc_dev),
        .wr_data   (acc_data),
        .sel_flat  (sel_flat)
    );

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_gate
        irq_dev_gate #(.KIND(dev_kind_e'(DEV_KINDS[2*d +: 2]))) u_gate (
            .req   (dev_req[d]),
            .stat  (dev_stat[d*STAT_W +: STAT_W]),
            .gated (gated[d])
        );
    end

    irq_pin_mux #(.NUM_DEV(NUM_DEV)) u_mux (
        .sel_flat (sel_flat),
        .gated    (gated),
        .line_dat (irq_dat),
        .line_oe  (irq_oe)
    );

    // read data: the addressed select, zero-extended, only on a hit
    always_comb begin
        cfg_rdata = '0;
        if (acc_hit) begin
            for (int d = 0; d < NUM_DEV; d++) begin
                if (acc_dev == DEV_W'(d)) begin
                    cfg_rdata = {{(8-SEL_W){1'b0}}, sel_flat[d*SEL_W +: SEL_W]};
                end
            end
        end
    end
endmodule

// File: rtl/irq_route_checker.sv
module irq_route_checker
    import irq_route_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_reset,
    input logic                 cfg_req,
    input logic                 cfg_ack,
    input logic [7:0]           cfg_rdata,
    input logic [NUM_LINES-1:0] irq_dat,
    input logic [NUM_LINES-1:0] irq_oe
);
    assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack && !bus_reset) |=> cfg_ack);

    assert_rdata_high_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ack |-> (cfg_rdata[7:4] == 4'h0));

    assert_dat_needs_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_dat & ~irq_oe) == '0));

    assert_bus_reset_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (irq_oe == '0));

    assert_no_adjacent_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ack |=> !cfg_ack);
endmodule

bind irq_route_matrix irq_route_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .cfg_req   (cfg_req),
    .cfg_ack   (cfg_ack),
    .cfg_rdata (cfg_rdata),
    .irq_dat   (irq_dat),
    .irq_oe    (irq_oe)
);

// File: tb/test_irq_route_matrix.sv
module test_irq_route_matrix;
    localparam int NDEV = 4;
    localparam int DW   = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst_n, bus_reset, cfg_req, cfg_we, cfg_ack;
    logic [DW-1:0]   cfg_dev;
    logic [7:0]      cfg_idx, cfg_wdata, cfg_rdata;
    logic [NDEV-1:0] dev_req;
    logic [NDEV*8-1:0] dev_stat;
    logic [14:0]     irq_dat, irq_oe;

    irq_route_matrix #(.NUM_DEV(NDEV), .DEV_W(DW)) i_irq_route_matrix (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_dev(cfg_dev),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata),
        .dev_req(dev_req), .dev_stat(dev_stat),
        .irq_dat(irq_dat), .irq_oe(irq_oe)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [3:0] msel[NDEV];
    bit         done = 0;

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", rq, act, exp);
        end
    endtask

    // gate model from R5..R8; device d has kind d
    function automatic logic gate_ok(int d, logic [7:0] s);
        case (d)
            0: return s[3];
            1: return s[4] && !(s[7] && s[2]);
            2: return (|s[3:0]) && s[5];
            default: return s[0];
        endcase
    endfunction

    function automatic logic [14:0] model_oe();
        logic [14:0] v = '0;
        for (int d = 0; d < NDEV; d++) if (msel[d] != 0) v[msel[d]-1] = 1'b1;
        return v;
    endfunction

    function automatic logic [14:0] model_dat();
        logic [14:0] v = '0;
        for (int d = 0; d < NDEV; d++)
            if (msel[d] != 0 && dev_req[d] && gate_ok(d, dev_stat[d*8 +: 8]))
                v[msel[d]-1] = 1'b1;
        return v;
    endfunction

    task automatic check_lines(string rq);
        #1;
        check({rq, " oe"},  32'(irq_oe),  32'(model_oe()));
        check({rq, " dat"}, 32'(irq_dat), 32'(model_dat()));
    endtask

    // scoreboard monitor: every ack pops one expected read value
    always @(negedge clk) begin
        if (rst_n === 1'b1 && cfg_ack === 1'b1) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12 unexpected ack actual 1 expected 0");
            end else begin
                check(tag_q.pop_front(), 32'(cfg_rdata), 32'(exp_q.pop_front()));
            end
        end
    end

    function automatic logic [7:0] predict(logic [DW-1:0] dev, logic [7:0] idx);
        if (idx == 8'h70 && int'(dev) < NDEV) return {4'h0, msel[dev]};
        return 8'h00;
    endfunction

    task automatic cfg_op(logic we, logic [DW-1:0] dev, logic [7:0] idx,
                          logic [7:0] data, string rq);
        exp_q.push_back(predict(dev, idx));
        tag_q.push_back(rq);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = we; cfg_dev = dev; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_req = 1'b0;
        if (we && idx == 8'h70 && int'(dev) < NDEV) msel[dev] = data[3:0];
        @(negedge clk);
    endtask

    task automatic set_stat(int d, logic [7:0] s);
        dev_stat[d*8 +: 8] = s;
    endtask

    initial begin
        #(4 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_reset = 1'b0; cfg_req = 1'b0; cfg_we = 1'b0;
        cfg_dev = '0; cfg_idx = '0; cfg_wdata = '0; dev_req = '0; dev_stat = '0;
        for (int d = 0; d < NDEV; d++) msel[d] = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_lines("R1 reset");
        cfg_op(1'b0, 3'd0, 8'h70, 8'h00, "R1 reset read");

        // R2: write with upper nibble set, read back
        cfg_op(1'b1, 3'd0, 8'h70, 8'hF6, "R2 write");
        cfg_op(1'b0, 3'd0, 8'h70, 8'h00, "R2 readback");

        // R3: other index and absent device
        cfg_op(1'b1, 3'd1, 8'h71, 8'h05, "R3 bad index write");
        cfg_op(1'b0, 3'd1, 8'h70, 8'h00, "R3 read after bad index");
        cfg_op(1'b0, 3'd1, 8'h71, 8'h00, "R3 bad index read");
        cfg_op(1'b1, 3'd5, 8'h70, 8'h03, "R3 absent device write");
        cfg_op(1'b0, 3'd5, 8'h70, 8'h00, "R3 absent device read");
        check_lines("R4 single select");

        // R5 floppy on IRQ6, R10 gated off
        dev_req[0] = 1'b1; set_stat(0, 8'h00);
        check_lines("R10 floppy gated off");
        set_stat(0, 8'h08);
        check_lines("R5 floppy dma enable");

        // R6 parallel on IRQ7
        cfg_op(1'b1, 3'd1, 8'h70, 8'h07, "R6 select write");
        dev_req[1] = 1'b1; set_stat(1, 8'h10);
        check_lines("R6 parallel enabled");
        set_stat(1, 8'h94);
        check_lines("R6 extended mode service set");
        set_stat(1, 8'h90);
        check_lines("R6 extended mode service clear");
        set_stat(1, 8'h80);
        check_lines("R6 irq enable clear");

        // R7 serial on IRQ15
        cfg_op(1'b1, 3'd2, 8'h70, 8'h0F, "R7 select write");
        dev_req[2] = 1'b1; set_stat(2, 8'h20);
        check_lines("R7 out2 without ier");
        set_stat(2, 8'h24);
        check_lines("R7 out2 with ier");
        set_stat(2, 8'h04);
        check_lines("R7 ier without out2");

        // R8 keyboard on IRQ1
        cfg_op(1'b1, 3'd3, 8'h70, 8'h01, "R8 select write");
        dev_req[3] = 1'b1; set_stat(3, 8'h01);
        check_lines("R8 keyboard enabled");

        // R9 sharing IRQ6 with floppy
        cfg_op(1'b1, 3'd3, 8'h70, 8'h06, "R9 select write");
        set_stat(0, 8'h00);
        check_lines("R9 shared one active");
        set_stat(3, 8'h00);
        check_lines("R9 shared none active");
        set_stat(0, 8'h08);
        check_lines("R9 shared other active");

        // R4 select zero releases lines
        cfg_op(1'b1, 3'd0, 8'h70, 8'h00, "R4 clear floppy");
        check_lines("R4 still held by keyboard");
        cfg_op(1'b1, 3'd3, 8'h70, 8'h00, "R4 clear keyboard");
        check_lines("R4 line released");

        // R12 held request served every other cycle
        exp_q.push_back(predict(3'd1, 8'h70)); tag_q.push_back("R12 first ack");
        exp_q.push_back(predict(3'd1, 8'h70)); tag_q.push_back("R12 second ack");
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b0; cfg_dev = 3'd1; cfg_idx = 8'h70;
        repeat (4) @(negedge clk);
        cfg_req = 1'b0;
        @(negedge clk);
        check("R12 pending acks", 32'(exp_q.size()), 32'd0);

        // R11 bus reset, overlapping a write
        exp_q.push_back(predict(3'd2, 8'h70)); tag_q.push_back("R11 write during reset");
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b1; cfg_dev = 3'd2; cfg_idx = 8'h70; cfg_wdata = 8'h09;
        @(negedge clk);
        cfg_req = 1'b0; bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
        for (int d = 0; d < NDEV; d++) msel[d] = 4'h0;
        check_lines("R11 bus reset");
        cfg_op(1'b0, 3'd2, 8'h70, 8'h00, "R11 read after reset");
        cfg_op(1'b0, 3'd1, 8'h70, 8'h00, "R11 read other after reset");

        repeat (2) @(negedge clk);
        check("R2 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule